// File: doc/BRIEF.md
# Cycle-Slip Counting Lock Detector

This block judges whether a phase-locked loop is in lock by watching two single-cycle strobes that share the system clock. One strobe is the reference tick and the other is the divided-feedback tick. A small signed counter tracks how far one stream has run ahead of the other. Each time either stream gets two ticks ahead, the block records one whole-cycle slip and brings the lead back to one tick. No phase window is used, so even a tiny frequency error is noticed, one slip at a time.

Slips are counted, and the lock flag falls when the count goes past a threshold set by parameter. The flag then stays low for a hold-off window measured in reference ticks. If a full window passes with no slips, the flag rises again. If slips stay below the threshold for a whole window, the count is forgotten. A small error that slips now and then therefore never drops the flag. A large, steady error keeps the flag low all the time. An error in between makes the flag toggle, with its rate set by the error.

A set of status pins shows the detector to the rest of the system. Each pin has three enable bits, and the pin is the OR of the sources whose bits are set.

Top module: `slip_lock_detector`

## Requirements
- R1: A reference tick and a feedback tick in the same cycle cancel. A lead of a single tick is never a slip. A slip is recorded when one stream gets two ticks ahead of the other, and the lead then stands at one tick.
- R2: Slips are detected in both directions, whether the reference is ahead or the feedback is ahead. Both directions count the same way toward lock loss.
- R3: While locked, `lock_o` stays high as long as at most THRESH slips have been counted. It goes low right after the clock edge that samples the (THRESH+1)-th counted slip.
- R4: The slip count is cleared when lock loss is signalled. A single later slip therefore does not signal lock loss again.
- R5: After lock loss, `lock_o` stays low until HOLD reference ticks have been sampled with no slip. It rises right after the edge that samples the HOLD-th such tick. Feedback ticks do not advance the window.
- R6: A slip during the hold-off that does not go past the threshold keeps `lock_o` low when that window ends. A fresh window starts, and lock is declared at the end of the first window that is free of slips.
- R7: When a window of HOLD reference ticks ends without lock loss, the slip count is cleared. THRESH slips in each window therefore never drop `lock_o`.
- R8: A synchronous active-low reset clears all state and leaves `lock_o` low. The first lock comes after HOLD reference ticks with no slip.
- R9: If slips keep arriving faster than a window can complete, `lock_o` stays low the whole time.
- R10: Status pin i is the OR of its enabled sources. Enable bit 3i selects lock loss (`!lock_o`), bit 3i+1 selects `ref_lost_i`, and bit 3i+2 selects `ref_sel_i`. With none of its three bits set, the pin is low. The path is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared by both tick streams |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick_i | input | 1 | One-cycle reference strobe |
| fb_tick_i | input | 1 | One-cycle divided-feedback strobe |
| ref_lost_i | input | 1 | Reference-loss indication, a status source |
| ref_sel_i | input | 1 | Selected-reference indication, a status source |
| stat_en_i | input | NUM_STATUS*3 | Per-pin enable bits for the three status sources |
| lock_o | output | 1 | High while lock is declared |
| status_o | output | NUM_STATUS | Status pins, each the OR of its enabled sources |

## Verification
The tick counter, the slip count, the window and the lock flag each pass through one register. A change in `lock_o` caused by a tick therefore shows right after the edge that samples that tick. The status pins follow their inputs and `lock_o` in the same cycle. The bench drives ticks 1 ns after a rising edge, lets the next edge sample them, and reads `lock_o` 1 ns after that edge. It keeps track of the reference-tick count within each window, so the relock cycle and each cycle where the flag must not move are known ahead of time. Status pins are swept over every enable pattern and source value, with the lock flag held both low and high, and are compared 1 ns after each input change.

// File: rtl/sld_pkg.sv
// Package: shared types for the cycle-slip lock detector.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package sld_pkg;

    // Number of selectable status sources per status pin.
    localparam int SRC_N = 3;

    // Outcome of one cycle of tick comparison.
    typedef enum logic [1:0] {
        SLIP_NONE      = 2'd0,
        SLIP_REF_AHEAD = 2'd1,
        SLIP_FB_AHEAD  = 2'd2
    } slip_kind_t;

    // Lock judgement.
    typedef enum logic {
        ST_UNLOCKED = 1'b0,
        ST_LOCKED   = 1'b1
    } lock_state_t;

    // Status sources; bit order matches enable bits 3i, 3i+1, 3i+2.
    typedef struct packed {
        logic ref_select;   // bit 2
        logic ref_loss;     // bit 1
        logic lock_loss;    // bit 0
    } sld_src_t;

endpackage

// File: rtl/sld_slip_detect.sv
// Module: sld_slip_detect
// Tracks the signed lead of the reference tick stream over the feedback
// stream. The lead is held in {-1, 0, +1}. When an update would reach +2
// or -2, the cycle is flagged as a slip and the lead is stepped back by one.
// Assumes: both strobes are synchronous to clk and one cycle wide.
module sld_slip_detect
    import sld_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick_i,
    input  logic       fb_tick_i,
    output slip_kind_t slip_o
);

    logic signed [1:0] lead_q;
    logic signed [1:0] lead_d;
    logic signed [2:0] step;
    logic signed [2:0] lead_next;

    // Purpose: net step of the lead this cycle; simultaneous ticks cancel.
    always_comb begin
        step = 3'sd0;
        if (ref_tick_i && !fb_tick_i) begin
            step = 3'sd1;
        end else if (!ref_tick_i && fb_tick_i) begin
            step = -3'sd1;
        end
    end

    // Purpose: classify the cycle and compute the clamped next lead.
    always_comb begin
        lead_next = $signed({lead_q[1], lead_q}) + step;
        slip_o    = SLIP_NONE;
        lead_d    = lead_next[1:0];
        if (lead_next == 3'sd2) begin
            slip_o = SLIP_REF_AHEAD;
            lead_d = 2'sd1;
        end else if (lead_next == -3'sd2) begin
            slip_o = SLIP_FB_AHEAD;
            lead_d = -2'sd1;
        end
    end

    // Purpose: lead register with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_q <= 2'sd0;
        end else begin
            lead_q <= lead_d;
        end
    end

    // R1: the stored lead never holds the two-tick value.
    p_lead_bounded_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lead_q != -2'sd2);

    // R1: coincident ticks never produce a slip.
    p_cancel_no_slip_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tick_i && fb_tick_i) |-> (slip_o == SLIP_NONE));

    // R2: a feedback-ahead slip leaves the lead at -1.
    p_fb_slip_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_o == SLIP_FB_AHEAD) |=> (lead_q == -2'sd1));

    // R1: a reference-ahead slip leaves the lead at +1.
    p_ref_slip_lead_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_o == SLIP_REF_AHEAD) |=> (lead_q == 2'sd1));

endmodule

// File: rtl/sld_lock_ctrl.sv
// Module: sld_lock_ctrl
// Counts slips, declares lock loss once the count would pass THRESH, and
// runs the hold-off window in reference ticks. When a window ends, the slip
// count is cleared. A window that ends with no slip declares lock.
// Assumes: THRESH >= 1, HOLD >= 1, CNT_W holds THRESH, WIN_W holds HOLD-1.
module sld_lock_ctrl
    import sld_pkg::*;
#(
    parameter int THRESH = 4,
    parameter int HOLD   = 1000,
    parameter int CNT_W  = 3,
    parameter int WIN_W  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick_i,
    input  logic slip_i,
    output logic lock_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [WIN_W-1:0] win_q;
    lock_state_t      state_q;
    logic             loss;
    logic             expire;

    // Purpose: decode lock loss and window end for this cycle.
    always_comb begin
        loss   = slip_i && (cnt_q == CNT_W'(THRESH));
        expire = ref_tick_i && (win_q == WIN_W'(HOLD - 1));
    end

    // Purpose: hold-off window counter in reference ticks; restarts on loss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (loss) begin
            win_q <= '0;
        end else if (ref_tick_i) begin
            win_q <= expire ? '0 : win_q + WIN_W'(1);
        end
    end

    // Purpose: slip counter; cleared on loss and at every window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (loss) begin
            cnt_q <= '0;
        end else if (expire) begin
            cnt_q <= slip_i ? CNT_W'(1) : '0;
        end else if (slip_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Purpose: lock state; falls on loss, rises at a window end free of slips.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_UNLOCKED;
        end else if (loss) begin
            state_q <= ST_UNLOCKED;
        end else if (expire && (cnt_q == '0) && !slip_i) begin
            state_q <= ST_LOCKED;
        end
    end

    assign lock_o = (state_q == ST_LOCKED);

    // R3: the count never exceeds the threshold.
    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(THRESH));

    // R3: lock falls only after a slip on top of a full count.
    p_fall_needs_excess_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_o) |-> ($past(slip_i) && ($past(cnt_q) == CNT_W'(THRESH))));

    // R4: loss clears the slip count and drops lock.
    p_cnt_clear_on_loss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        loss |=> ((cnt_q == '0) && !lock_o));

    // R5: lock rises only at a window end with no slip counted.
    p_relock_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> ($past(expire) && ($past(cnt_q) == '0) && !$past(slip_i)));

    // R5: the window counter stays inside the hold-off length.
    p_window_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_q <= WIN_W'(HOLD - 1));

    // R5: feedback-only cycles do not move the window.
    p_window_ref_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_tick_i && !loss) |=> $stable(win_q));

    // R7: a window end without loss leaves at most one slip counted.
    p_window_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !loss) |=> (cnt_q <= CNT_W'(1)));

endmodule

// File: rtl/sld_status_mux.sv
// Module: sld_status_mux
// Drives each status pin as the OR of the sources whose enable bit is set.
// Enable bit 3i picks lock loss, 3i+1 reference loss, 3i+2 reference select.
// Assumes: sources are already synchronous to clk; the path is combinational.
module sld_status_mux
    import sld_pkg::*;
#(
    parameter int NUM_STATUS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  sld_src_t                    src_i,
    input  logic [NUM_STATUS*SRC_N-1:0] en_i,
    output logic [NUM_STATUS-1:0]       status_o
);

    for (genvar g = 0; g < NUM_STATUS; g++) begin : g_pin
        logic [SRC_N-1:0] pin_en;

        // Purpose: slice this pin's enables and OR the selected sources.
        always_comb begin
            pin_en      = en_i[g*SRC_N +: SRC_N];
            status_o[g] = |(pin_en & src_i);
        end

        // R10: a pin with no enable bit set stays low.
        p_unused_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_en == '0) |-> !status_o[g]);

        // R10: an enabled, active lock-loss source always reaches the pin.
        p_lock_loss_seen_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_en[0] && src_i.lock_loss) |-> status_o[g]);
    end

endmodule

// File: rtl/slip_lock_detector.sv
// Module: slip_lock_detector (top)
// Cycle-slip counting lock detector. It compares reference and feedback
// ticks, counts whole-cycle slips, drops the lock flag once more than THRESH
// slips are seen, holds it low for a window of HOLD reference ticks, and
// routes lock loss, reference loss and reference select to status pins.
// Assumes: THRESH >= 1, HOLD >= 1; all inputs are synchronous to clk.
module slip_lock_detector
    import sld_pkg::*;
#(
    parameter int THRESH     = 4,
    parameter int HOLD       = 1000,
    parameter int NUM_STATUS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ref_tick_i,
    input  logic                        fb_tick_i,
    input  logic                        ref_lost_i,
    input  logic                        ref_sel_i,
    input  logic [NUM_STATUS*SRC_N-1:0] stat_en_i,
    output logic                        lock_o,
    output logic [NUM_STATUS-1:0]       status_o
);

    localparam int CNT_W = (THRESH < 1) ? 1 : $clog2(THRESH + 1);
    localparam int WIN_W = (HOLD < 2) ? 1 : $clog2(HOLD);

    slip_kind_t slip_kind;
    logic       slip;
    sld_src_t   src;

    sld_slip_detect u_slip_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick_i (ref_tick_i),
        .fb_tick_i  (fb_tick_i),
        .slip_o     (slip_kind)
    );

    // Purpose: either slip direction counts the same toward lock loss.
    always_comb begin
        slip = (slip_kind != SLIP_NONE);
    end

    sld_lock_ctrl #(
        .THRESH (THRESH),
        .HOLD   (HOLD),
        .CNT_W  (CNT_W),
        .WIN_W  (WIN_W)
    ) u_lock_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick_i (ref_tick_i),
        .slip_i     (slip),
        .lock_o     (lock_o)
    );

    // Purpose: gather the three status sources in enable-bit order.
    always_comb begin
        src.lock_loss  = !lock_o;
        src.ref_loss   = ref_lost_i;
        src.ref_select = ref_sel_i;
    end

    sld_status_mux #(
        .NUM_STATUS (NUM_STATUS)
    ) u_status_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src),
        .en_i     (stat_en_i),
        .status_o (status_o)
    );

    // R8: the cycle after reset is released, lock is low.
    p_reset_unlocked_r8: assert property (@(posedge clk)
        !rst_n |=> !lock_o);

endmodule

// File: tb/slip_lock_detector_bench.sv
`timescale 1ns/1ps
module slip_lock_detector_bench;

    localparam int THR = 2;
    localparam int HLD = 8;
    localparam int NS  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_tick = 1'b0;
    logic          fb_tick = 1'b0;
    logic          ref_lost = 1'b0;
    logic          ref_sel = 1'b0;
    logic [NS*3-1:0] stat_en = '0;
    logic          lock;
    logic [NS-1:0] status;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    slip_lock_detector #(
        .THRESH     (THR),
        .HOLD       (HLD),
        .NUM_STATUS (NS)
    ) u_slip_lock_detector (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick_i (ref_tick),
        .fb_tick_i  (fb_tick),
        .ref_lost_i (ref_lost),
        .ref_sel_i  (ref_sel),
        .stat_en_i  (stat_en),
        .lock_o     (lock),
        .status_o   (status)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle of ticks; return 1 ns after the sampling edge.
    task automatic cyc(input logic r, input logic f);
        ref_tick = r;
        fb_tick  = f;
        @(posedge clk);
        #1;
        ref_tick = 1'b0;
        fb_tick  = 1'b0;
    endtask

    task automatic sweep_status(input logic lk);
        for (int e = 0; e < (1 << (NS*3)); e++) begin
            for (int rl = 0; rl < 2; rl++) begin
                for (int rs = 0; rs < 2; rs++) begin
                    stat_en  = (NS*3)'(e);
                    ref_lost = rl[0];
                    ref_sel  = rs[0];
                    #1;
                    for (int p = 0; p < NS; p++) begin
                        int ex;
                        ex = (((e >> (3*p)) & 1) & int'(!lk))
                           | (((e >> (3*p+1)) & 1) & rl)
                           | (((e >> (3*p+2)) & 1) & rs);
                        chk("R10 status pin", int'(status[p]), ex);
                    end
                end
            end
        end
        stat_en  = '0;
        ref_lost = 1'b0;
        ref_sel  = 1'b0;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R8: reset state.
        repeat (3) @(posedge clk);
        #1;
        chk("R8 lock in reset", int'(lock), 0);
        chk("R10 status with no enables", int'(status), 0);
        rst_n = 1'b1;

        // R8: first lock after HLD clean reference ticks.
        for (int i = 0; i < HLD - 1; i++) begin
            cyc(1, 1);
            chk("R8 before first window ends", int'(lock), 0);
        end
        cyc(1, 1);
        chk("R8 first lock", int'(lock), 1);

        // R1: single-tick leads and coincident ticks are not slips.
        for (int i = 0; i < 6; i++) begin
            cyc(1, 0);
            cyc(0, 1);
            chk("R1 one-tick lead", int'(lock), 1);
        end
        cyc(0, 1);
        cyc(1, 0);
        cyc(1, 1);
        chk("R1 window end while locked", int'(lock), 1);

        // R3: reference-ahead slips up to and past the threshold.
        cyc(1, 0);
        cyc(1, 0);
        chk("R3 one slip", int'(lock), 1);
        cyc(1, 0);
        chk("R3 slips at threshold", int'(lock), 1);
        cyc(1, 0);
        chk("R3 slip past threshold", int'(lock), 0);

        // R5: clean relock after HLD reference ticks.
        for (int i = 0; i < HLD - 1; i++) begin
            cyc(1, 1);
            chk("R5 hold-off", int'(lock), 0);
        end
        cyc(1, 1);
        chk("R5 relock", int'(lock), 1);
        cyc(0, 1);
        chk("R5 feedback tick only", int'(lock), 1);

        // R7: THRESH slips per window, both directions, three windows.
        for (int w = 0; w < 3; w++) begin
            if (w == 1) begin
                cyc(0, 1); cyc(0, 1); cyc(0, 1);
                chk("R7 fb slips in window", int'(lock), 1);
                cyc(1, 0);
                for (int i = 0; i < HLD - 1; i++) begin
                    cyc(1, 1);
                    chk("R7 rest of window", int'(lock), 1);
                end
            end else begin
                cyc(1, 0); cyc(1, 0); cyc(1, 0);
                chk("R7 ref slips in window", int'(lock), 1);
                cyc(0, 1);
                for (int i = 0; i < HLD - 3; i++) begin
                    cyc(1, 1);
                    chk("R7 rest of window", int'(lock), 1);
                end
            end
        end

        // R2: feedback-ahead slips cause lock loss.
        cyc(0, 1);
        cyc(0, 1);
        cyc(0, 1);
        chk("R2 fb slips at threshold", int'(lock), 1);
        cyc(0, 1);
        chk("R2 fb slip past threshold", int'(lock), 0);

        // R6 and R4: one slip in the hold-off delays relock by one window.
        cyc(0, 1);
        chk("R4 single slip after loss", int'(lock), 0);
        cyc(1, 0);
        for (int i = 0; i < HLD - 1; i++) begin
            cyc(1, 1);
            chk("R6 dirty window", int'(lock), 0);
        end
        for (int i = 0; i < HLD - 1; i++) begin
            cyc(1, 1);
            chk("R6 second window", int'(lock), 0);
        end
        cyc(1, 1);
        chk("R6 relock after clean window", int'(lock), 1);

        // R4: a fresh full count is needed again after relock.
        cyc(1, 0);
        cyc(1, 0);
        cyc(1, 0);
        chk("R4 count restarted", int'(lock), 1);
        cyc(1, 0);
        chk("R4 loss again", int'(lock), 0);

        // R9: continuous slips keep the flag low.
        for (int i = 0; i < 40; i++) begin
            cyc(1, 0);
            chk("R9 continuous slips", int'(lock), 0);
        end

        // R8: reset again, then R10 sweeps with lock low and high.
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R8 lock after second reset", int'(lock), 0);
        rst_n = 1'b1;
        sweep_status(1'b0);
        for (int i = 0; i < HLD; i++) begin
            cyc(1, 1);
        end
        chk("R8 lock after second acquire", int'(lock), 1);
        sweep_status(1'b1);

        summary();
    end

endmodule